// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

This block is a binary counter with no direction input. It has two strobe inputs, one that counts up and one that counts down. Both strobes are ordinary level inputs sampled by the single system clock. Each one passes through a synchronizer, and its rising edge is found by comparing the synchronized level with the level one clock earlier. A rising edge on one strobe is a legal count only while the other strobe is high. An illegal edge does not change the count and sets a sticky error flag.

A master clear forces the count to zero. An active-low parallel load copies the data input into the count while it is held. The clear and the load are sampled synchronously and take effect on the next clock. Two active-low terminal-count outputs repeat the low phase of the matching strobe while the count sits at its top or bottom value. These outputs can drive the strobe inputs of a second instance, so that two instances chain into a wider counter.

Top module: `updn_strobe_counter`

## Requirements
- R1: During and after the system reset `rst`, the count is 0, both terminal-count outputs are 1 and `err` is 0. If both strobes are held high through reset, the count does not change after reset is released.
- R2: A rising edge on `up_stb` while `dn_stb` is high adds one to the count. The count changes on the third rising clock edge after the first clock edge that samples the strobe high, and stays unchanged at the two edges before it.
- R3: A rising edge on `dn_stb` while `up_stb` is high subtracts one from the count, with the same latency as R2.
- R4: The count wraps in binary: from 2^WIDTH-1 to 0 when counting up, and from 0 to 2^WIDTH-1 when counting down.
- R5: When `clear` is 1 at a clock edge, the count is 0 after that edge, whatever `load_n`, `din` and the strobes are doing.
- R6: When `load_n` is 0 and `clear` is 0 at a clock edge, the count equals `din` after that edge. Strobe edges that arrive during a load do not change the loaded value.
- R7: `tc_up_n` goes to 0 when the count is all ones and the synchronized `up_stb` is low. It returns to 1 when the strobe returns high, at the same clock edge where the count wraps to 0.
- R8: `tc_dn_n` goes to 0 when the count is 0 and the synchronized `dn_stb` is low. It returns to 1 when the strobe returns high, at the same clock edge where the count wraps to all ones.
- R9: A strobe rising edge while the other strobe is low, or both strobes rising in the same synchronized cycle, leaves the count unchanged and sets `err` to 1. `err` then stays 1 until it is cleared.
- R10: `clear` resets `err` to 0 at the next clock edge.
- R11: When one instance's `tc_up_n` drives a second instance's `up_stb`, and its `tc_dn_n` drives the second instance's `dn_stb`, the pair counts up and down as a single counter of 2·WIDTH bits, wrapping across the boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Master clear, active high, has priority over everything else |
| load_n | input | 1 | Parallel load, active low |
| din | input | WIDTH | Parallel load data |
| up_stb | input | 1 | Count-up strobe, counts on its rising edge |
| dn_stb | input | 1 | Count-down strobe, counts on its rising edge |
| q | output | WIDTH | Count value |
| tc_up_n | output | 1 | Terminal count up, active low |
| tc_dn_n | output | 1 | Terminal count down, active low |
| err | output | 1 | Sticky flag for illegal strobe edges |

## Verification
The bench counts through both wrap points. A design with a wrong carry or borrow would land on the wrong value or stall there. It measures the latency of a strobe edge cycle by cycle, so an extra or a missing pipeline stage shows up as an early or late count. It holds one strobe low while pulsing the other, and it raises both strobes together. An edge check that was too loose would count here when it should only set the flag, and a flag that was not sticky would drop when the held strobe returns. It also checks that clear overrides load, that a load holds its value against a strobe edge, and that two chained instances carry and borrow across the 4-bit boundary. Each of these cases fails visibly if the terminal-count outputs release late or early.

// File: rtl/updn_strobe_pkg.sv
package updn_strobe_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_INC  = 2'd1,
    EV_DEC  = 2'd2,
    EV_BAD  = 2'd3
  } strobe_ev_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  // idle level is high so a strobe held high through reset makes no edge
  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b1;
    else     chain[0] <= raw;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b1;
        else     chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
  import updn_strobe_pkg::*;
(
  input  logic       up_lvl,
  input  logic       up_rise,
  input  logic       dn_lvl,
  input  logic       dn_rise,
  output strobe_ev_e ev
);
  logic inc_ok;
  logic dec_ok;

  assign inc_ok = up_rise & dn_lvl & ~dn_rise;
  assign dec_ok = dn_rise & up_lvl & ~up_rise;

  always_comb begin
    if (inc_ok)                 ev = EV_INC;
    else if (dec_ok)            ev = EV_DEC;
    else if (up_rise | dn_rise) ev = EV_BAD;
    else                        ev = EV_NONE;
  end
endmodule

// File: rtl/count_core.sv
module count_core
  import updn_strobe_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  strobe_ev_e       ev,
  output logic [WIDTH-1:0] q,
  output logic             err
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || clear)  q <= '0;
    else if (!load_n)  q <= din;
    else if (ev == EV_INC) q <= q + ONE;
    else if (ev == EV_DEC) q <= q - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst || clear)       err <= 1'b0;
    else if (ev == EV_BAD)  err <= 1'b1;
  end
endmodule

// File: rtl/tc_gen.sv
module tc_gen #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] q,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic             tc_up_n,
  output logic             tc_dn_n
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_up_n <= 1'b1;
      tc_dn_n <= 1'b1;
    end else begin
      tc_up_n <= ~((q == TOP) & ~up_lvl);
      tc_dn_n <= ~((q == '0)  & ~dn_lvl);
    end
  end
endmodule

// File: rtl/updn_strobe_counter.sv
module updn_strobe_counter
  import updn_strobe_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             up_stb,
  input  logic             dn_stb,
  output logic [WIDTH-1:0] q,
  output logic             tc_up_n,
  output logic             tc_dn_n,
  output logic             err
);
  localparam int N_STB = 2;

  logic [N_STB-1:0] raw;
  logic [N_STB-1:0] lvl;
  logic [N_STB-1:0] rise;
  strobe_ev_e       ev;

  assign raw = {dn_stb, up_stb};

  generate
    for (genvar s = 0; s < N_STB; s++) begin : g_sync
      strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (raw[s]),
        .lvl  (lvl[s]),
        .rise (rise[s])
      );
    end
  endgenerate

  strobe_decode u_dec (
    .up_lvl  (lvl[0]),
    .up_rise (rise[0]),
    .dn_lvl  (lvl[1]),
    .dn_rise (rise[1]),
    .ev      (ev)
  );

  count_core #(.WIDTH(WIDTH)) u_core (
    .clk    (clk),
    .rst    (rst),
    .clear  (clear),
    .load_n (load_n),
    .din    (din),
    .ev     (ev),
    .q      (q),
    .err    (err)
  );

  tc_gen #(.WIDTH(WIDTH)) u_tc (
    .clk     (clk),
    .rst     (rst),
    .q       (q),
    .up_lvl  (lvl[0]),
    .dn_lvl  (lvl[1]),
    .tc_up_n (tc_up_n),
    .tc_dn_n (tc_dn_n)
  );
endmodule

// File: rtl/updn_strobe_counter_chk.sv
module updn_strobe_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             clear,
  input logic             load_n,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             tc_up_n,
  input logic             tc_dn_n,
  input logic             err
);
  logic [WIDTH-1:0] q_d;
  logic [WIDTH-1:0] step;

  always_ff @(posedge clk) q_d <= q;
  assign step = q - q_d;

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (rst)
    clear |=> (q == '0));

  assert_load_follow_R6: assert property (@(posedge clk) disable iff (rst)
    (!clear && !load_n) |=> (q == $past(din)));

  // R2 R3 R4: outside clear and load the count moves by at most one, modulo 2^WIDTH
  assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!clear && load_n) |=> (step == '0 || step == {{(WIDTH-1){1'b0}}, 1'b1} || step == {WIDTH{1'b1}}));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (err && !clear) |=> err);

  assert_err_cleared_R10: assert property (@(posedge clk) disable iff (rst)
    clear |=> !err);

  assert_tcup_at_top_R7: assert property (@(posedge clk) disable iff (rst)
    !tc_up_n |-> ($past(q) == {WIDTH{1'b1}}));

  assert_tcdn_at_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !tc_dn_n |-> ($past(q) == '0));
endmodule

bind updn_strobe_counter updn_strobe_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .clear   (clear),
  .load_n  (load_n),
  .din     (din),
  .q       (q),
  .tc_up_n (tc_up_n),
  .tc_dn_n (tc_dn_n),
  .err     (err)
);

// File: tb/sim_updn_strobe_counter.sv
`timescale 1ns/1ps
module sim_updn_strobe_counter;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clr = 1'b0;
  logic         ld_n = 1'b1;
  logic [W-1:0] d = '0;
  logic         up = 1'b1;
  logic         dn = 1'b1;
  logic [W-1:0] q;
  logic         tcu_n, tcd_n, err;

  logic         c_clr = 1'b0;
  logic         c_ld_n = 1'b1;
  logic [7:0]   c_d = '0;
  logic         c_up = 1'b1;
  logic         c_dn = 1'b1;
  logic [W-1:0] lo_q, hi_q;
  logic         lo_tcu_n, lo_tcd_n, hi_tcu_n, hi_tcd_n, lo_err, hi_err;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] exp_q = '0;
  logic [7:0]   exp8 = '0;

  always #5 clk = ~clk;

  updn_strobe_counter #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .clear(clr), .load_n(ld_n), .din(d),
    .up_stb(up), .dn_stb(dn), .q(q), .tc_up_n(tcu_n), .tc_dn_n(tcd_n), .err(err));

  updn_strobe_counter #(.WIDTH(W)) u_lo (
    .clk(clk), .rst(rst), .clear(c_clr), .load_n(c_ld_n), .din(c_d[3:0]),
    .up_stb(c_up), .dn_stb(c_dn), .q(lo_q), .tc_up_n(lo_tcu_n), .tc_dn_n(lo_tcd_n), .err(lo_err));

  updn_strobe_counter #(.WIDTH(W)) u_hi (
    .clk(clk), .rst(rst), .clear(c_clr), .load_n(c_ld_n), .din(c_d[7:4]),
    .up_stb(lo_tcu_n), .dn_stb(lo_tcd_n), .q(hi_q), .tc_up_n(hi_tcu_n), .tc_dn_n(hi_tcd_n), .err(hi_err));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic pulse_up();
    up = 1'b0; step(4); up = 1'b1; step(4);
  endtask

  task automatic pulse_dn();
    dn = 1'b0; step(4); dn = 1'b1; step(4);
  endtask

  task automatic do_clear();
    clr = 1'b1; step(1); clr = 1'b0; step(1);
    exp_q = '0;
  endtask

  task automatic do_load(input logic [W-1:0] v);
    d = v; ld_n = 1'b0; step(1); ld_n = 1'b1; step(1);
    exp_q = v;
  endtask

  // R1: reset values, strobes held high through reset
  task automatic t_reset();
    rst = 1'b1; step(3);
    chk("R1 q in reset", q, 0);
    rst = 1'b0; step(6);
    chk("R1 q after reset", q, 0);
    chk("R1 tc_up_n", tcu_n, 1);
    chk("R1 tc_dn_n", tcd_n, 1);
    chk("R1 err", err, 0);
  endtask

  // R5 R6: clear over load, load follows din, load beats a strobe edge
  task automatic t_clear_load();
    d = 4'h7; ld_n = 1'b0; clr = 1'b1; step(2);
    chk("R5 clear beats load", q, 0);
    clr = 1'b0; step(1);
    chk("R6 load follows din", q, 4'h7);
    d = 4'h5; step(1);
    chk("R6 load tracks din change", q, 4'h5);
    up = 1'b0; step(4); up = 1'b1; step(5);
    chk("R6 strobe edge ignored under load", q, 4'h5);
    ld_n = 1'b1; step(1);
    exp_q = 4'h5;
    chk("R6 holds after load", q, exp_q);
  endtask

  // R2: exact latency of an up edge
  task automatic t_latency();
    do_load(4'h3);
    up = 1'b0; step(4);
    up = 1'b1;
    step(2);
    chk("R2 no change at second edge", q, 4'h3);
    step(1);
    chk("R2 change at third edge", q, 4'h4);
    step(4);
    exp_q = 4'h4;
  endtask

  // R2 R4: count up across the top
  task automatic t_up_wrap();
    do_load(4'hD);
    for (int i = 0; i < 5; i++) begin
      pulse_up(); exp_q = exp_q + 1'b1;
      chk("R4 up wrap step", q, exp_q);
    end
  endtask

  // R3 R4: count down across zero
  task automatic t_dn_wrap();
    do_load(4'h1);
    for (int i = 0; i < 3; i++) begin
      pulse_dn(); exp_q = exp_q - 1'b1;
      chk("R3 down wrap step", q, exp_q);
    end
  endtask

  // R7: tc_up_n copies the low phase of up at the top
  task automatic t_tc_up();
    do_load(4'hF);
    up = 1'b0; step(4);
    chk("R7 tc_up_n low at top", tcu_n, 0);
    chk("R7 tc_dn_n stays high", tcd_n, 1);
    up = 1'b1; step(4);
    chk("R7 tc_up_n released", tcu_n, 1);
    chk("R7 wrapped to 0", q, 0);
    exp_q = '0;
  endtask

  // R8: tc_dn_n copies the low phase of dn at zero
  task automatic t_tc_dn();
    do_clear();
    dn = 1'b0; step(4);
    chk("R8 tc_dn_n low at zero", tcd_n, 0);
    chk("R8 tc_up_n stays high", tcu_n, 1);
    dn = 1'b1; step(4);
    chk("R8 tc_dn_n released", tcd_n, 1);
    chk("R8 wrapped to top", q, 4'hF);
    exp_q = 4'hF;
  endtask

  // R9 R10: illegal edges, sticky flag, clear
  task automatic t_illegal();
    do_load(4'h6);
    dn = 1'b0; step(4);
    pulse_up();
    chk("R9 illegal up edge ignored", q, 4'h6);
    chk("R9 err set", err, 1);
    dn = 1'b1; step(4);
    exp_q = 4'h5;
    chk("R9 dn return counts down", q, exp_q);
    chk("R9 err sticky", err, 1);
    do_clear();
    chk("R10 err cleared", err, 0);
    do_load(4'hA);
    up = 1'b0; dn = 1'b0; step(4);
    up = 1'b1; dn = 1'b1; step(4);
    chk("R9 simultaneous rise ignored", q, 4'hA);
    chk("R9 simultaneous rise flagged", err, 1);
    do_clear();
    chk("R10 err cleared again", err, 0);
  endtask

  // R11: two instances chained into 8 bits
  task automatic t_cascade();
    c_d = 8'hFE; c_ld_n = 1'b0; step(1); c_ld_n = 1'b1; step(2);
    exp8 = 8'hFE;
    chk("R11 cascade load", {hi_q, lo_q}, exp8);
    for (int i = 0; i < 3; i++) begin
      c_up = 1'b0; step(8); c_up = 1'b1; step(8);
      exp8 = exp8 + 1'b1;
      chk("R11 cascade up", {hi_q, lo_q}, exp8);
    end
    for (int i = 0; i < 2; i++) begin
      c_dn = 1'b0; step(8); c_dn = 1'b1; step(8);
      exp8 = exp8 - 1'b1;
      chk("R11 cascade down", {hi_q, lo_q}, exp8);
    end
    chk("R11 no cascade error", {hi_err, lo_err}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_clear_load();
    t_latency();
    t_up_wrap();
    t_dn_wrap();
    t_tc_up();
    t_tc_dn();
    t_illegal();
    t_cascade();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule